// File: doc/BRIEF.md
# Serial Memory Slave with Protected Status Register

This block is the target side of a four-wire serial memory link. While the active-low select is held low, it samples an 8-bit command on the serial input, MSB first. It then serves one of four commands. The first streams bytes out of a small on-chip byte array, starting at a 16-bit address. The second returns the status byte. The third sets the write-enable latch. The fourth replaces the writable part of the status byte. A status write is not applied at once. It starts a modelled non-volatile programming period, and the status byte shows a busy flag for that period.

The block runs on one system clock that is much faster than the serial clock. The four serial pins are registered on that clock, and serial clock edges are found from the registered copies. The serial output leaves the block as a data bit plus an output enable; the pad ring builds the three-state driver from the two. The byte array is a behavioural register file. It is filled through a plain load port before traffic starts. Both idle levels of the serial clock are accepted (modes 0 and 3). Input is sampled on rising serial clock edges, and output changes on falling edges.

Status byte layout, MSB to LSB: protect-enable, three bits that always read 0, protect-field high, protect-field low, write-enable latch, busy.

Top module: `spi_mem_slave`

## Requirements
- R1: Commands are decoded from the first 8 bits after select falls, MSB first: 0x03 array read, 0x05 status read, 0x06 set write-enable, 0x01 status write.
- R2: so_oe is 1 only while a read or status-read response is being shifted out, and is 0 whenever select is high. After any other opcode the block ignores the serial input and holds so_oe at 0 until select rises.
- R3: An array read takes a 16-bit address after its opcode, of which only the low ADDR_W bits (11 by default) are used. Data bit 7 of the addressed byte appears on so_d after the serial clock falling edge that follows the last address bit, then one bit per falling edge.
- R4: The read address advances after every 8 bits shifted out. After address 2^ADDR_W-1 it wraps to 0, so the stream continues until select rises.
- R5: A status read returns the live status byte MSB first. The byte repeats for as long as clocks continue, and the read is honoured during the busy period.
- R6: A status write changes only bit 7 (protect-enable) and bits 3:2 (protect field). Bits 6:4 always read 0.
- R7: The write-enable latch (bit 1) is set only when select rises exactly 8 bits after a 0x06 opcode while not busy. A status write with the latch clear is discarded. The latch clears when the programming period ends.
- R8: A status write is applied only if select rises exactly after 16 bits (opcode plus 8 data bits). Fewer or more bits discard it.
- R9: With protect-enable at 1, a low wp_n inhibits status writes. wp_n going low at any point while select is still low aborts the pending status write.
- R10: Once a status write has been applied, wp_n has no effect on it. With protect-enable at 0, wp_n is ignored.
- R11: An applied status write sets busy (bit 0) for WR_CYCLES clock cycles. A status write issued during busy is discarded.
- R12: Mode 0 (clock idles low) and mode 3 (clock idles high) give identical results.
- R13: After reset the status byte is 0x00 and so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sck |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out drive enable |
| ld_we | input | 1 | Array preload write strobe |
| ld_addr | input | ADDR_W | Array preload address |
| ld_data | input | 8 | Array preload data |

## Verification
Each pin passes through one register stage, and the edge detector acts on the next clock, so a serial clock edge shows on so_d two system clocks later. The bench holds every serial clock phase for four system clocks and samples so_d and so_oe at the end of the low phase, just before it drives the rising edge. An applied status write starts busy three clocks after select rises. The bench therefore reads status with a fresh status-read command, which lands well inside the 400-cycle busy window. For the settled value it waits 450 further clocks after the write.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int unsigned CMD_BITS  = 8;
    localparam int unsigned ADDR_BITS = 16;
    localparam logic [7:0]  WR_MASK   = 8'h8C;

    typedef enum logic [7:0] {
        OP_WRSR = 8'h01,
        OP_READ = 8'h03,
        OP_RDSR = 8'h05,
        OP_WREN = 8'h06
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_SHOUT,
        ST_WDATA,
        ST_WEND,
        ST_WRENEND,
        ST_DROP
    } st_e;

    typedef struct packed {
        logic       wpen;
        logic [2:0] rsv;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } stat_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic desel;
        logic si;
        logic wp_n;
    } pin_t;

    function automatic stat_t wr_merge(stat_t cur, logic [7:0] wd);
        return stat_t'((cur & ~WR_MASK) | (wd & WR_MASK));
    endfunction

    function automatic st_e opc_next(logic [7:0] op, logic wr_ok);
        case (op)
            OP_READ: return ST_ADDR;
            OP_RDSR: return ST_SHOUT;
            OP_WREN: return ST_WRENEND;
            OP_WRSR: return wr_ok ? ST_WDATA : ST_DROP;
            default: return ST_DROP;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_mem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output pin_t pins
);

    logic sck_q, sck_p, cs_q, cs_p, si_q, wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sck_p <= 1'b0;
            cs_q  <= 1'b1;
            cs_p  <= 1'b1;
            si_q  <= 1'b0;
            wp_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            sck_p <= sck_q;
            cs_q  <= cs_n;
            cs_p  <= cs_q;
            si_q  <= si;
            wp_q  <= wp_n;
        end
    end

    always_comb begin
        pins.rise  = sck_q & ~sck_p;
        pins.fall  = ~sck_q & sck_p;
        pins.sel   = ~cs_q;
        pins.desel = cs_q & ~cs_p;
        pins.si    = si_q;
        pins.wp_n  = wp_q;
    end

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status
    import spi_mem_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  logic [7:0] wdata,
    input  logic       wren_set,
    output stat_t      stat
);

    localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

    stat_t            st_q;
    logic [CNT_W-1:0] timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            timer <= '0;
        end else if (commit) begin
            st_q      <= wr_merge(st_q, wdata);
            st_q.busy <= 1'b1;
            timer     <= CNT_W'(WR_CYCLES);
        end else if (st_q.busy) begin
            timer <= timer - 1'b1;
            if (timer == CNT_W'(1)) begin
                st_q.busy <= 1'b0;
                st_q.wel  <= 1'b0;
            end
        end else if (wren_set) begin
            st_q.wel <= 1'b1;
        end
    end

    assign stat = st_q;

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_t              pins,
    input  stat_t             stat,
    input  logic [7:0]        mem_rd,
    output logic [ADDR_W-1:0] mem_ra,
    output logic              so_d,
    output logic              so_oe,
    output logic              commit,
    output logic [7:0]        wbyte,
    output logic              wren_set
);

    localparam int unsigned CNT_W = $clog2(ADDR_BITS);

    st_e                  st;
    logic [CNT_W-1:0]     cnt;
    logic [ADDR_BITS-1:0] shin;
    logic [ADDR_BITS-1:0] nxt;
    logic [7:0]           outsr;
    logic [7:0]           cur;
    logic [7:0]           src;
    logic [2:0]           ocnt;
    logic                 osrc_stat;
    logic [ADDR_W-1:0]    optr;
    logic                 wp_block;
    logic                 wr_ok;

    assign nxt      = {shin[ADDR_BITS-2:0], pins.si};
    assign wp_block = stat.wpen & ~pins.wp_n;
    assign wr_ok    = stat.wel & ~stat.busy & ~wp_block;
    assign cur      = osrc_stat ? 8'(stat) : mem_rd;
    assign src      = (ocnt == 3'd0) ? cur : outsr;
    assign mem_ra   = optr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            shin      <= '0;
            outsr     <= '0;
            ocnt      <= '0;
            osrc_stat <= 1'b0;
            optr      <= '0;
            so_d      <= 1'b0;
            so_oe     <= 1'b0;
            commit    <= 1'b0;
            wbyte     <= '0;
            wren_set  <= 1'b0;
        end else begin
            commit   <= 1'b0;
            wren_set <= 1'b0;
            if (!pins.sel) begin
                st    <= ST_IDLE;
                so_oe <= 1'b0;
                cnt   <= '0;
                ocnt  <= '0;
                if (pins.desel) begin
                    commit   <= (st == ST_WEND) && !wp_block;
                    wren_set <= (st == ST_WRENEND);
                end
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        st  <= ST_OPC;
                        cnt <= '0;
                    end
                    ST_OPC: begin
                        if (pins.rise) begin
                            shin <= nxt;
                            cnt  <= cnt + 1'b1;
                            if (cnt == CNT_W'(CMD_BITS - 1)) begin
                                cnt       <= '0;
                                st        <= opc_next(nxt[7:0], wr_ok);
                                osrc_stat <= (nxt[7:0] == OP_RDSR);
                                ocnt      <= '0;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (pins.rise) begin
                            shin <= nxt;
                            cnt  <= cnt + 1'b1;
                            if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                                optr <= nxt[ADDR_W-1:0];
                                st   <= ST_SHOUT;
                                ocnt <= '0;
                            end
                        end
                    end
                    ST_SHOUT: begin
                        if (pins.fall) begin
                            so_oe <= 1'b1;
                            so_d  <= src[7];
                            outsr <= {src[6:0], 1'b0};
                            ocnt  <= ocnt + 1'b1;
                            if (ocnt == 3'd7 && !osrc_stat) begin
                                optr <= optr + 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (wp_block) begin
                            st <= ST_DROP;
                        end else if (pins.rise) begin
                            shin <= nxt;
                            cnt  <= cnt + 1'b1;
                            if (cnt == CNT_W'(7)) begin
                                wbyte <= nxt[7:0];
                                st    <= ST_WEND;
                            end
                        end
                    end
                    ST_WEND: begin
                        if (wp_block || pins.rise) begin
                            st <= ST_DROP;
                        end
                    end
                    ST_WRENEND: begin
                        if (pins.rise) begin
                            st <= ST_DROP;
                        end
                    end
                    ST_DROP: begin
                        st <= ST_DROP;
                    end
                    default: begin
                        st <= ST_DROP;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned WR_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              wp_n,
    output logic              so_d,
    output logic              so_oe,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data
);

    pin_t              pins;
    stat_t             stat;
    logic              commit;
    logic              wren_set;
    logic [7:0]        wbyte;
    logic [7:0]        mem_rd;
    logic [ADDR_W-1:0] mem_ra;

    spi_pin_sync i_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .cs_n (cs_n),
        .si   (si),
        .wp_n (wp_n),
        .pins (pins)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) i_array (
        .clk     (clk),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .raddr   (mem_ra),
        .rdata   (mem_rd)
    );

    spi_mem_status #(.WR_CYCLES(WR_CYCLES)) i_status (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .wdata    (wbyte),
        .wren_set (wren_set),
        .stat     (stat)
    );

    spi_mem_engine #(.ADDR_W(ADDR_W)) i_engine (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins),
        .stat     (stat),
        .mem_rd   (mem_rd),
        .mem_ra   (mem_ra),
        .so_d     (so_d),
        .so_oe    (so_oe),
        .commit   (commit),
        .wbyte    (wbyte),
        .wren_set (wren_set)
    );

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
    import spi_mem_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input pin_t  pins,
    input stat_t stat,
    input logic  commit,
    input logic  so_oe
);

    // R2: output drive only follows a cycle with select active
    a_r2_oe_only_selected: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> $past(pins.sel));

    // R7 and R11: an applied write needs the latch and an idle timer
    a_r7_commit_needs_wel: assert property (@(posedge clk) disable iff (rst)
        commit |-> (stat.wel && !stat.busy));

    // R9: no write applied while protection was active
    a_r9_commit_wp_ok: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(stat.wpen && !pins.wp_n));

    // R11: busy starts only from an applied write
    a_r11_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.busy) |-> $past(commit));

    // R6: writable fields move only on an applied write
    a_r6_fields_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable({stat.wpen, stat.bp}) |-> $past(commit));

endmodule

bind spi_mem_slave spi_mem_slave_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .pins   (pins),
    .stat   (stat),
    .commit (commit),
    .so_oe  (so_oe)
);

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;

    localparam int HALF = 4;
    localparam int AW   = 11;
    localparam int WAIT_WR = 450;

    // {address[15:0], byte count[7:0], expected first byte[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {16'h0000, 8'd3, 8'h00},
        {16'h07FE, 8'd4, 8'h1E},
        {16'hF812, 8'd2, 8'h12},
        {16'h0123, 8'd2, 8'h03},
        {16'h0456, 8'd3, 8'hD6},
        {16'h07FF, 8'd2, 8'h1F}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so_d, so_oe;
    logic ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic m3 = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    spi_mem_slave i_spi_mem_slave (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
        .so_d(so_d), .so_oe(so_oe), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    function automatic logic [7:0] pat(logic [AW-1:0] a);
        return a[7:0] ^ {a[10:8], 5'b00000};
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_start(input logic mode3);
        m3 = mode3;
        sck = mode3;
        hold(2);
        cs_n = 1'b0;
        hold(HALF);
    endtask

    task automatic spi_end();
        if (!m3) sck = 1'b0;
        hold(HALF);
        cs_n = 1'b1;
        hold(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                        output logic oe_any, output logic oe_all);
        rx = '0; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = 0; i < nb; i++) begin
            sck = 1'b0;
            si = tx[7-i];
            hold(HALF);
            rx = {rx[6:0], so_d};
            oe_any = oe_any | so_oe;
            oe_all = oe_all & so_oe;
            sck = 1'b1;
            hold(HALF);
        end
    endtask

    task automatic rdsr(input logic mode3, output logic [7:0] st, output logic oe_all);
        logic [7:0] d; logic a, b;
        spi_start(mode3);
        xfer(8'h05, 8, d, a, b);
        xfer(8'h00, 8, st, a, oe_all);
        spi_end();
    endtask

    task automatic check_status(input string req, input logic [7:0] exp);
        logic [7:0] st; logic oa;
        rdsr(1'b0, st, oa);
        check(req, {24'h0, st}, {24'h0, exp});
    endtask

    task automatic cmd(input logic [7:0] op, input int opbits, input logic [7:0] d, input int dbits);
        logic [7:0] r; logic a, b;
        spi_start(1'b0);
        xfer(op, opbits, r, a, b);
        if (dbits > 0) xfer(d, dbits, r, a, b);
        spi_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, st; logic a, b;
        hold(5);
        rst = 1'b0;
        hold(2);
        // R13: reset state
        check("R13 so_oe after reset", {31'h0, so_oe}, 32'h0);
        check_status("R13 R5 status after reset", 8'h00);

        for (int k = 0; k < (1 << AW); k++) begin
            ld_we = 1'b1; ld_addr = AW'(k); ld_data = pat(AW'(k));
            hold(1);
        end
        ld_we = 1'b0;

        // R3 R4 R12 R2: table-driven reads, alternating modes
        for (int v = 0; v < 6; v++) begin
            logic [15:0] ad; int n; logic [7:0] e; logic [AW-1:0] ak;
            ad = VEC[v][31:16]; n = int'(VEC[v][15:8]); e = VEC[v][7:0];
            spi_start(v[0]);
            xfer(8'h03, 8, r, a, b);
            xfer(ad[15:8], 8, r, a, b);
            check("R2 no drive during address", {31'h0, a}, 32'h0);
            xfer(ad[7:0], 8, r, a, b);
            for (int k = 0; k < n; k++) begin
                ak = ad[AW-1:0] + AW'(k);
                xfer(8'h00, 8, r, a, b);
                check("R3 R4 R12 read byte", {24'h0, r}, {24'h0, (k == 0) ? e : pat(ak)});
                check("R2 drive during data", {31'h0, b}, 32'h1);
            end
            spi_end();
            check("R2 released after select", {31'h0, so_oe}, 32'h0);
        end

        // R5: status repeats while clocked
        spi_start(1'b0);
        xfer(8'h05, 8, r, a, b);
        xfer(8'h00, 8, r, a, b);
        xfer(8'h00, 8, st, a, b);
        spi_end();
        check("R5 repeated status", {r, st}, 32'h0);

        // R7: no latch, write discarded
        cmd(8'h01, 8, 8'hFF, 8);
        check_status("R7 write without latch", 8'h00);
        cmd(8'h06, 8, 8'h00, 0);
        check_status("R7 R1 latch set", 8'h02);

        // R6 R11: masked write, busy visible
        cmd(8'h01, 8, 8'hFF, 8);
        check_status("R6 R11 R5 busy read", 8'h8F);
        hold(WAIT_WR);
        check_status("R6 R7 after write", 8'h8C);

        // R11: write during busy discarded
        cmd(8'h06, 8, 8'h00, 0);
        cmd(8'h01, 8, 8'h8C, 8);
        cmd(8'h06, 8, 8'h00, 0);
        cmd(8'h01, 8, 8'h00, 8);
        hold(WAIT_WR);
        check_status("R11 write during busy", 8'h8C);

        // R9: protection inhibits
        wp_n = 1'b0;
        cmd(8'h06, 8, 8'h00, 0);
        cmd(8'h01, 8, 8'h00, 8);
        hold(WAIT_WR);
        wp_n = 1'b1;
        check_status("R9 inhibited write", 8'h8E);

        // R9: wp falls mid-data
        spi_start(1'b0);
        xfer(8'h01, 8, r, a, b);
        xfer(8'h00, 4, r, a, b);
        wp_n = 1'b0;
        xfer(8'h00, 4, r, a, b);
        spi_end();
        wp_n = 1'b1;
        hold(WAIT_WR);
        check_status("R9 abort mid write", 8'h8E);

        // R8: wrong bit counts
        cmd(8'h01, 8, 8'h00, 7);
        hold(WAIT_WR);
        check_status("R8 seven data bits", 8'h8E);
        spi_start(1'b0);
        xfer(8'h01, 8, r, a, b);
        xfer(8'h00, 8, r, a, b);
        xfer(8'h00, 1, r, a, b);
        spi_end();
        hold(WAIT_WR);
        check_status("R8 nine data bits", 8'h8E);

        // R10: wp after the write is applied
        cmd(8'h01, 8, 8'h04, 8);
        wp_n = 1'b0;
        check_status("R10 applied despite wp", 8'h07);
        hold(WAIT_WR);
        check_status("R10 settled", 8'h04);

        // R10: protect-enable 0 ignores wp
        cmd(8'h06, 8, 8'h00, 0);
        cmd(8'h01, 8, 8'h08, 8);
        hold(WAIT_WR);
        wp_n = 1'b1;
        check_status("R10 wp ignored", 8'h08);

        // R2 R1: unknown opcode
        spi_start(1'b0);
        xfer(8'hAB, 8, r, a, b);
        xfer(8'h00, 8, r, a, b);
        check("R2 R1 unknown opcode no drive", {31'h0, a}, 32'h0);
        xfer(8'h00, 8, r, a, b);
        check("R2 unknown opcode still silent", {31'h0, a}, 32'h0);
        spi_end();
        check_status("R1 unknown opcode no effect", 8'h08);

        // R7: latch command with an extra bit
        spi_start(1'b0);
        xfer(8'h06, 8, r, a, b);
        xfer(8'h00, 1, r, a, b);
        spi_end();
        check_status("R7 latch extra bit", 8'h08);

        // R12: status read in mode 3
        rdsr(1'b1, st, b);
        check("R12 mode 3 status", {24'h0, st}, 32'h08);
        check("R12 mode 3 drive", {31'h0, b}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule